// File: doc/BRIEF.md
# Record-to-Lane Stream Distributor

This block takes a stream of fixed-width records arriving from the memory side and steers each record into one of several parallel lanes of a stream register file. Each lane feeds exactly one arithmetic cluster. For every record the block also produces the write address inside the lane that receives it, so that the lane can store the record without keeping its own count.

Two placements are available, picked per stream by a mode input. In blocked placement each lane receives a contiguous run of a programmed number of records, `m`, before the next lane starts. In interleaved placement consecutive records are dealt to lanes in turn, wrapping after the last lane.

A start pulse latches the mode, the stream length and the run length. A valid/ready handshake on the input and one on each lane port carry the records. Each lane port has a single output register. A blocked target lane stalls the input without loss, and a one-cycle done pulse marks the end of the stream.

Top module: `record_lane_distributor`

## Requirements
- R1: Each accepted record is presented on exactly one lane port, with that lane's valid high, from the cycle after its acceptance. Every accepted record eventually appears, and no lane presents a record that was not accepted.
- R2: With mode 0 (blocked), the k-th record of a stream (k counted from 0) goes to lane (k div m) mod N with in-lane address k mod m. Here N is the number of lanes and m is the run length latched at start. A run length of 0 is treated as 1.
- R3: With mode 1 (interleaved), the k-th record (k counted from 0) goes to lane k mod N with in-lane address (k div N) mod 2^ADDR_W.
- R4: Mode, stream length and run length are sampled only when start is high while the block is idle. Changes on these inputs, and start pulses, during a stream have no effect on that stream.
- R5: While a lane port holds a record that is not taken (valid high, ready low), its data and address stay stable. In that case the input's ready is low whenever that lane is the next target. Records reach each lane in stream order.
- R6: `done` is high for exactly the one cycle after the last record of a stream is accepted. A start with stream length 0 gives `done` in the following cycle and delivers no records.
- R7: After reset, and whenever no stream is running, `busy` and `in_ready` are low. While reset is applied, no lane presents valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a stream when idle |
| mode | input | 1 | 0 = blocked, 1 = interleaved |
| stream_len | input | LEN_W | Number of records in the stream |
| run_len | input | ADDR_W | Records per lane in blocked mode |
| in_valid | input | 1 | Input record valid |
| in_data | input | REC_W | Input record |
| in_ready | output | 1 | Input record accepted when high with in_valid |
| lane_valid | output | NUM_LANES | Per-lane record valid |
| lane_data | output | NUM_LANES*REC_W | Per-lane record, lane i at bits i*REC_W upward |
| lane_addr | output | NUM_LANES*ADDR_W | Per-lane write address, lane i at bits i*ADDR_W upward |
| lane_ready | input | NUM_LANES | Per-lane consumer ready |
| busy | output | 1 | A stream is in progress |
| done | output | 1 | One-cycle end-of-stream pulse |

## Verification
A wrong lane or address counter shows up on the very next accepted record. That record appears at an unexpected lane port, or carries an address that differs from the reference, within one cycle of its acceptance. A wrong occupancy or ready path shows up as a lost, duplicated or reordered record when the reference queues are popped, or as `in_ready` high while the target lane is blocked, in the same cycle. A latching fault shows up as a placement switching in the middle of a stream after the bench disturbs the mode and length inputs. A fault in the end-of-stream state shows up as a `done` pulse that is missing, late or repeated one cycle after the final acceptance.

// File: rtl/rld_pkg.sv
package rld_pkg;
  typedef enum logic {
    PLACE_BLOCKED     = 1'b0,
    PLACE_INTERLEAVED = 1'b1
  } place_mode_e;

  function automatic int lane_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rld_sequencer.sv
module rld_sequencer
  import rld_pkg::*;
#(
  parameter int NUM_LANES = 16,
  parameter int ADDR_W    = 8,
  parameter int LEN_W     = 16,
  parameter int LANE_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 mode,
  input  logic [LEN_W-1:0]     stream_len,
  input  logic [ADDR_W-1:0]    run_len,
  input  logic                 in_valid,
  input  logic [NUM_LANES-1:0] lane_free,
  output logic                 in_ready,
  output logic                 accept,
  output logic [LANE_W-1:0]    lane_sel,
  output logic [ADDR_W-1:0]    lane_wr_addr,
  output logic                 busy,
  output logic                 done
);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);

  logic              active_q;
  place_mode_e       mode_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] run_q;
  logic [LANE_W-1:0] lane_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;
  logic              last_rec;
  logic [LANE_W-1:0] lane_inc;

  assign in_ready     = active_q && lane_free[lane_q];
  assign accept       = in_ready && in_valid;
  assign last_rec     = (cnt_q == len_q - LEN_W'(1));
  assign lane_inc     = (lane_q == LAST_LANE) ? '0 : lane_q + LANE_W'(1);
  assign lane_sel     = lane_q;
  assign lane_wr_addr = addr_q;
  assign busy         = active_q;
  assign done         = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      mode_q   <= PLACE_BLOCKED;
      len_q    <= '0;
      cnt_q    <= '0;
      run_q    <= ADDR_W'(1);
      lane_q   <= '0;
      addr_q   <= '0;
      done_q   <= 1'b0;
    end else if (start && !active_q) begin
      active_q <= (stream_len != '0);
      mode_q   <= place_mode_e'(mode);
      len_q    <= stream_len;
      run_q    <= (run_len == '0) ? ADDR_W'(1) : run_len;
      cnt_q    <= '0;
      lane_q   <= '0;
      addr_q   <= '0;
      done_q   <= (stream_len == '0);
    end else begin
      done_q <= accept && last_rec;
      if (accept) begin
        cnt_q <= cnt_q + LEN_W'(1);
        if (last_rec) active_q <= 1'b0;
        if (mode_q == PLACE_BLOCKED) begin
          if (addr_q == run_q - ADDR_W'(1)) begin
            addr_q <= '0;
            lane_q <= lane_inc;
          end else begin
            addr_q <= addr_q + ADDR_W'(1);
          end
        end else begin
          lane_q <= lane_inc;
          if (lane_q == LAST_LANE) addr_q <= addr_q + ADDR_W'(1);
        end
      end
    end
  end

  // R2: a blocked run never runs past its programmed length
  p_blocked_addr_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (active_q && mode_q == PLACE_BLOCKED) |-> (addr_q < run_q));

  // R4: latched stream parameters do not move while a stream runs
  p_params_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (active_q && !(accept && last_rec)) |=> ($stable(mode_q) && $stable(len_q) && $stable(run_q)));

  // R6: final acceptance is followed by the done pulse
  p_done_after_last_r6: assert property (@(posedge clk) disable iff (rst)
    (accept && last_rec) |=> (done_q && !active_q));
endmodule

// File: rtl/rld_lane_reg.sv
module rld_lane_reg #(
  parameter int REC_W  = 64,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [REC_W-1:0]  load_data,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              ready,
  output logic              free,
  output logic              valid,
  output logic [REC_W-1:0]  data,
  output logic [ADDR_W-1:0] addr
);
  logic              valid_q;
  logic [REC_W-1:0]  data_q;
  logic [ADDR_W-1:0] addr_q;

  assign free  = !valid_q || ready;
  assign valid = valid_q;
  assign data  = data_q;
  assign addr  = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
    end else if (ready) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      data_q <= load_data;
      addr_q <= load_addr;
    end
  end

  // R5: an untaken record is held unchanged
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !ready) |=> (valid_q && $stable(data_q) && $stable(addr_q)));

  // R5: a new record never lands on one still waiting
  p_no_overwrite_r5: assert property (@(posedge clk) disable iff (rst)
    load |-> (!valid_q || ready));
endmodule

// File: rtl/record_lane_distributor.sv
module record_lane_distributor
  import rld_pkg::*;
#(
  parameter int NUM_LANES = 16,
  parameter int REC_W     = 64,
  parameter int ADDR_W    = 8,
  parameter int LEN_W     = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        mode,
  input  logic [LEN_W-1:0]            stream_len,
  input  logic [ADDR_W-1:0]           run_len,
  input  logic                        in_valid,
  input  logic [REC_W-1:0]            in_data,
  output logic                        in_ready,
  output logic [NUM_LANES-1:0]        lane_valid,
  output logic [NUM_LANES*REC_W-1:0]  lane_data,
  output logic [NUM_LANES*ADDR_W-1:0] lane_addr,
  input  logic [NUM_LANES-1:0]        lane_ready,
  output logic                        busy,
  output logic                        done
);
  localparam int LANE_W = lane_bits(NUM_LANES);

  logic [NUM_LANES-1:0] lane_free;
  logic [NUM_LANES-1:0] lane_load;
  logic                 accept;
  logic [LANE_W-1:0]    lane_sel;
  logic [ADDR_W-1:0]    wr_addr;

  rld_sequencer #(
    .NUM_LANES(NUM_LANES), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LANE_W(LANE_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .stream_len(stream_len), .run_len(run_len), .in_valid(in_valid),
    .lane_free(lane_free), .in_ready(in_ready), .accept(accept),
    .lane_sel(lane_sel), .lane_wr_addr(wr_addr), .busy(busy), .done(done)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign lane_load[i] = accept && (lane_sel == LANE_W'(i));

    rld_lane_reg #(.REC_W(REC_W), .ADDR_W(ADDR_W)) u_reg (
      .clk(clk), .rst(rst), .load(lane_load[i]),
      .load_data(in_data), .load_addr(wr_addr), .ready(lane_ready[i]),
      .free(lane_free[i]), .valid(lane_valid[i]),
      .data(lane_data[i*REC_W +: REC_W]),
      .addr(lane_addr[i*ADDR_W +: ADDR_W])
    );
  end

  // R1: at most one lane takes each accepted record
  p_one_load_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_load));

  // R7: no input acceptance while idle
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !accept);
endmodule

// File: tb/sim_record_lane_distributor.sv
module sim_record_lane_distributor;
  localparam int NL = 4;
  localparam int RW = 16;
  localparam int AW = 6;
  localparam int LW = 10;

  logic clk = 1'b0;
  logic rst;
  logic start, mode, in_valid, in_ready, busy, done;
  logic [LW-1:0] stream_len;
  logic [AW-1:0] run_len;
  logic [RW-1:0] in_data;
  logic [NL-1:0] lane_valid, lane_ready;
  logic [NL*RW-1:0] lane_data;
  logic [NL*AW-1:0] lane_addr;

  always #2.5 clk = ~clk;

  record_lane_distributor #(.NUM_LANES(NL), .REC_W(RW), .ADDR_W(AW), .LEN_W(LW)) u0 (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .stream_len(stream_len),
    .run_len(run_len), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .lane_valid(lane_valid), .lane_data(lane_data), .lane_addr(lane_addr),
    .lane_ready(lane_ready), .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit timed_out = 0;

  // reference state
  logic [RW+AW:0] q [NL][$];
  bit m_active = 0;
  bit m_mode = 0;
  int m_len = 0, m_run = 1, m_k = 0;
  bit exp_done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit queues_empty();
    for (int i = 0; i < NL; i++) if (q[i].size() != 0) return 0;
    return 1;
  endfunction

  task automatic step(input int rp, input int vp, input bit noisy);
    int tgt;
    int k0;
    int lane;
    int adr;
    bit exp_rdy;
    logic [RW+AW:0] e;
    @(negedge clk);
    cycles++;
    if (cycles > 150000) timed_out = 1;
    for (int i = 0; i < NL; i++) lane_ready[i] = ($urandom_range(99) < rp);
    in_valid = m_active && ($urandom_range(99) < vp);
    in_data  = RW'($urandom);
    start = 1'b0;
    if (noisy) begin
      mode       = $urandom_range(1);
      stream_len = LW'($urandom_range(40));
      run_len    = AW'($urandom_range(7));
      start      = m_active && ($urandom_range(7) == 0);
    end
    #1;
    chk(done === exp_done, "R6", "done", done, exp_done);
    exp_done = 0;
    chk(busy === m_active, "R7", "busy", busy, m_active);
    // expected in_ready from model target and observed lane occupancy
    if (m_active) begin
      k0 = m_k;
      tgt = m_mode ? (k0 % NL) : ((k0 / m_run) % NL);
      exp_rdy = !lane_valid[tgt] || lane_ready[tgt];
    end else begin
      exp_rdy = 0;
    end
    chk(in_ready === exp_rdy, m_active ? "R5" : "R7", "in_ready", in_ready, exp_rdy);
    // lane outputs
    for (int i = 0; i < NL; i++) begin
      if (lane_valid[i] && lane_ready[i]) begin
        if (q[i].size() == 0) begin
          chk(0, "R1", $sformatf("unexpected record lane %0d", i), lane_data[i*RW +: RW], 0);
        end else begin
          e = q[i].pop_front();
          chk(lane_data[i*RW +: RW] === e[RW+AW-1:AW], "R1",
              $sformatf("data lane %0d", i), lane_data[i*RW +: RW], e[RW+AW-1:AW]);
          chk(lane_addr[i*AW +: AW] === e[AW-1:0], e[RW+AW] ? "R3" : "R2",
              $sformatf("addr lane %0d", i), lane_addr[i*AW +: AW], e[AW-1:0]);
        end
      end
    end
    // acceptance at the coming edge
    if (in_valid && in_ready && m_active) begin
      k0 = m_k;
      if (m_mode) begin lane = k0 % NL; adr = (k0 / NL) % (1 << AW); end
      else        begin lane = (k0 / m_run) % NL; adr = k0 % m_run; end
      q[lane].push_back({m_mode, in_data, AW'(adr)});
      m_k++;
      if (m_k == m_len) begin
        m_active = 0;
        exp_done = 1;
      end
    end
  endtask

  task automatic run_stream(input bit md, input int len, input int run,
                            input int rp, input int vp, input bit noisy);
    @(negedge clk);
    cycles++;
    start = 1'b1; mode = md; stream_len = LW'(len); run_len = AW'(run);
    in_valid = 1'b0;
    lane_ready = '1;
    #1;
    // lanes drained beforehand, so no handshakes to account for here
    m_mode = md; m_len = len; m_run = (run == 0) ? 1 : run; m_k = 0;
    m_active = (len != 0);
    exp_done = (len == 0);
    do begin
      step(rp, vp, noisy);
    end while (!timed_out && (m_active || exp_done || !queues_empty()));
    start = 1'b0;
    chk(queues_empty(), "R1", "records left undelivered", 0, 0);
  endtask

  initial begin
    rst = 1'b1; start = 0; mode = 0; stream_len = '0; run_len = '0;
    in_valid = 0; in_data = '0; lane_ready = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(lane_valid === '0, "R7", "lane_valid in reset", lane_valid, 0);
    chk(in_ready === 1'b0, "R7", "in_ready in reset", in_ready, 0);
    chk(busy === 1'b0, "R7", "busy in reset", busy, 0);
    chk(done === 1'b0, "R6", "done in reset", done, 0);
    @(negedge clk); rst = 1'b0;

    run_stream(0, 16, 4, 100, 100, 0);   // R2 blocked, exact fill
    run_stream(1, 16, 4, 100, 100, 0);   // R3 interleaved
    run_stream(0, 11, 3, 100, 100, 0);   // R2 partial last run
    run_stream(1, 13, 0, 100, 100, 0);   // R3 uneven length
    run_stream(0, 9, 0, 100, 100, 0);    // R2 run length 0 as 1
    run_stream(0, 20, 2, 100, 100, 0);   // R2 lane wrap after last lane
    run_stream(0, 0, 3, 100, 100, 0);    // R6 empty stream
    run_stream(1, 30, 2, 30, 70, 0);     // R5 heavy back-pressure
    run_stream(0, 30, 5, 20, 90, 0);     // R5 blocked with stalls
    run_stream(1, 25, 3, 60, 60, 1);     // R4 noisy inputs mid-stream
    run_stream(0, 25, 3, 60, 60, 1);     // R4 noisy inputs mid-stream
    for (int s = 0; s < 30 && !timed_out; s++)
      run_stream($urandom_range(1), $urandom_range(1, 60), $urandom_range(7),
                 $urandom_range(20, 100), $urandom_range(20, 100), s[0]);
    // R7 idle after streams
    @(negedge clk); #1;
    chk(busy === 1'b0 && in_ready === 1'b0, "R7", "idle after streams", {busy, in_ready}, 0);
    if (timed_out) chk(0, "R1", "watchdog expired", cycles, 150000);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule